// File: doc/BRIEF.md
# Clause 45 MDIO frame engine

This block turns one 32-bit management frame word, written by a host, into a complete serial management transaction on an MDC/MDIO pair. The host writes the word through a write strobe. The block raises a busy flag and waits for the next falling edge of the divided management clock. It then shifts out a run of 32 preamble ones, followed by the 14 header bits: start code, opcode, port address and device address. The two turnaround bits and the 16 address or data bits come last. MDC is produced inside the block by dividing the system clock.

Frames that write to the PHY are driven fully. These are the Clause 45 address and write frames, and Clause 22 frames whose opcode is not a read. Turnaround is driven as one then zero. For read and post-read-increment frames, the block releases the line through turnaround and the data phase. It samples the PHY's 16 bits on rising MDC edges and, when the frame ends, stores them in the low half of the frame register. The host then reads the result through the readback port. The start code is sent exactly as written, so a Clause 22 frame is chosen only through that field.

The state machine has five states. IDLE goes to PREAMBLE on the first falling MDC edge while busy. PREAMBLE goes to HEADER after 32 bits. HEADER goes to TURN after 14 bits. TURN goes to DATA after 2 bits. DATA returns to IDLE after 16 bits, and this last transition clears busy.

Top module: `mdio_c45_engine`

## Requirements
- R1: A write strobe while not busy loads bits 31:0 of the write word into the frame register and sets busy on the next clock. Bits 63:32 of the write word are ignored, and bits 63:32 of the readback are always zero.
- R2: A write strobe while busy changes neither the frame register nor the transaction in progress.
- R3: MDC toggles every HALF_DIV system clocks and is low out of reset.
- R4: Each transaction opens with 32 MDC periods in which MDIO is driven high.
- R5: After the preamble, frame bits 31 down to 18 (start code, opcode, port, device) are driven MSB first, one per MDC period.
- R6: For a frame that is not a read, the two turnaround periods are driven 1 then 0, and then frame bits 15 down to 0 are driven MSB first.
- R7: A frame is a read when the start code (bits 31:30) is 01 and the opcode (bits 29:28) is 10. For any other start code, a frame is a read when opcode bit 29 is 1, which covers opcodes 11 (read) and 10 (post-read-increment).
- R8: For a read frame, the output enable is low during both turnaround periods and all 16 data periods. MDIO is sampled on each rising MDC edge of the data phase, MSB first.
- R9: At the end of a read frame, the 16 sampled bits replace frame bits 15:0, and bits 31:16 are kept.
- R10: MDIO output and output enable change only in the system-clock cycle in which MDC falls.
- R11: Busy stays high until the falling MDC edge that ends the 64th bit period and clears on that edge. Whenever the block is not busy, the output enable is low.
- R12: After reset, busy, output enable, MDC and the readback word are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe for the frame register |
| host_wdata | input | 64 | Host write word; only bits 31:0 are used |
| host_rdata | output | 64 | Frame register readback, upper half zero |
| busy | output | 1 | Transaction pending or in progress |
| mdc | output | 1 | Divided management clock |
| mdio_i | input | 1 | MDIO line as seen by the block |
| mdio_o | output | 1 | MDIO value driven by the block |
| mdio_oe | output | 1 | MDIO output enable, high when driving |

## Verification
Busy is due one system clock after the strobe, and the bench checks it on the next falling clock edge. Each MDIO bit is due before the rising MDC edge of its period. The bench logs the line at every rising MDC edge, counting from the first rising edge with the output enable high, and compares slot by slot with a stream built from the frame word. The PHY model drives the line 1 ns after each falling MDC edge. Busy clear and the readback update are due on the falling MDC edge after the 64th logged rise, so the bench samples them 2 ns after that edge, and it confirms busy was still high just after the 64th rise. MDC period and the falling-edge-only rule for output changes are tracked continuously on falling system-clock edges.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int FRAME_W   = 32;
    localparam int PRE_BITS  = 32;
    localparam int HDR_BITS  = 14;
    localparam int TA_BITS   = 2;
    localparam int DATA_BITS = 16;
    localparam int CNT_W     = $clog2(PRE_BITS);

    localparam logic [1:0] ST_C22 = 2'b01;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PRE,
        S_HDR,
        S_TURN,
        S_DATA
    } mdio_state_e;

    // read-type classification shared by FSM and top
    function automatic logic frame_is_read(input logic [1:0] st, input logic [1:0] op);
        return (st == ST_C22) ? (op == 2'b10) : op[1];
    endfunction
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] TERM = CW'(HALF_DIV - 1);

    logic [CW-1:0] div_cnt;
    logic          term;

    assign term      = (div_cnt == TERM);
    assign rise_tick = term && !mdc;
    assign fall_tick = term && mdc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
            mdc     <= 1'b0;
        end else if (term) begin
            div_cnt <= '0;
            mdc     <= ~mdc;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    a_r3_rise_raises_mdc: assert property (@(posedge clk) disable iff (!rst_n)
        rise_tick |=> mdc);
    a_r3_fall_lowers_mdc: assert property (@(posedge clk) disable iff (!rst_n)
        fall_tick |=> !mdc);
    a_r3_ticks_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rise_tick, fall_tick}));
endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fall_tick,
    input  logic               rise_tick,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame,
    input  logic               mdio_i,
    output logic               busy,
    output logic               mdio_o,
    output logic               mdio_oe,
    output logic               cap_en,
    output logic [DATA_BITS-1:0] rd_data
);
    mdio_state_e        state, state_n;
    logic [CNT_W-1:0]   cnt, cnt_n;
    logic               rd_frame;
    logic               last_bit;
    logic               nxt_o, nxt_oe;
    logic               unused_ta;

    assign rd_frame  = frame_is_read(frame[31:30], frame[29:28]);
    assign unused_ta = ^frame[17:16];
    assign last_bit  = fall_tick && (state == S_DATA) && (cnt == CNT_W'(DATA_BITS - 1));
    assign cap_en    = last_bit && rd_frame;

    // next state: advances only on falling MDC edges
    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        if (fall_tick) begin
            unique case (state)
                S_IDLE: begin
                    if (busy) begin
                        state_n = S_PRE;
                        cnt_n   = '0;
                    end
                end
                S_PRE: begin
                    if (cnt == CNT_W'(PRE_BITS - 1)) begin
                        state_n = S_HDR;
                        cnt_n   = '0;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
                S_HDR: begin
                    if (cnt == CNT_W'(HDR_BITS - 1)) begin
                        state_n = S_TURN;
                        cnt_n   = '0;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
                S_TURN: begin
                    if (cnt == CNT_W'(TA_BITS - 1)) begin
                        state_n = S_DATA;
                        cnt_n   = '0;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
                S_DATA: begin
                    if (cnt == CNT_W'(DATA_BITS - 1)) begin
                        state_n = S_IDLE;
                        cnt_n   = '0;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    // line value for the bit period that begins at this falling edge
    always_comb begin
        nxt_o  = 1'b1;
        nxt_oe = 1'b0;
        unique case (state_n)
            S_IDLE: begin
                nxt_o  = 1'b1;
                nxt_oe = 1'b0;
            end
            S_PRE: begin
                nxt_o  = 1'b1;
                nxt_oe = 1'b1;
            end
            S_HDR: begin
                nxt_o  = frame[5'(FRAME_W - 1) - cnt_n];
                nxt_oe = 1'b1;
            end
            S_TURN: begin
                nxt_o  = (cnt_n == '0);
                nxt_oe = !rd_frame;
            end
            S_DATA: begin
                nxt_o  = frame[4'(DATA_BITS - 1) - cnt_n[3:0]];
                nxt_oe = !rd_frame;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    // outputs, busy flag and read capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b0;
            rd_data <= '0;
        end else begin
            if (load) begin
                busy <= 1'b1;
            end else if (last_bit) begin
                busy <= 1'b0;
            end
            if (fall_tick) begin
                mdio_o  <= nxt_o;
                mdio_oe <= nxt_oe;
            end
            if (rise_tick && (state == S_DATA) && rd_frame) begin
                rd_data <= {rd_data[DATA_BITS-2:0], mdio_i};
            end
        end
    end

    a_r4_preamble_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PRE) |-> (mdio_oe && mdio_o));
    a_r8_read_released: assert property (@(posedge clk) disable iff (!rst_n)
        (((state == S_TURN) || (state == S_DATA)) && rd_frame) |-> !mdio_oe);
    a_r6_turn_first_high: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_TURN) && !rd_frame && (cnt == '0)) |-> (mdio_oe && mdio_o));
    a_r10_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_tick |=> ($stable(mdio_o) && $stable(mdio_oe)));
    a_r11_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> !mdio_oe);
endmodule

// File: rtl/mdio_c45_engine.sv
module mdio_c45_engine
    import mdio_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic [63:0] host_wdata,
    output logic [63:0] host_rdata,
    output logic        busy,
    output logic        mdc,
    input  logic        mdio_i,
    output logic        mdio_o,
    output logic        mdio_oe
);
    logic [FRAME_W-1:0]   frame_q;
    logic [DATA_BITS-1:0] rd_data;
    logic                 rise_tick, fall_tick;
    logic                 load, cap_en;
    logic                 unused_hi;

    assign load       = host_wr && !busy;
    assign unused_hi  = ^host_wdata[63:FRAME_W];
    assign host_rdata = {{(64 - FRAME_W){1'b0}}, frame_q};

    mdio_clk_div #(.HALF_DIV(HALF_DIV)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .fall_tick (fall_tick),
        .rise_tick (rise_tick),
        .load      (load),
        .frame     (frame_q),
        .mdio_i    (mdio_i),
        .busy      (busy),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .cap_en    (cap_en),
        .rd_data   (rd_data)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_q <= '0;
        end else if (load) begin
            frame_q <= host_wdata[FRAME_W-1:0];
        end else if (cap_en) begin
            frame_q[DATA_BITS-1:0] <= rd_data;
        end
    end

    a_r1_load_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !busy) |=> busy);
    a_r2_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && busy && !cap_en) |=> $stable(host_rdata));
    a_r11_released_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe);
endmodule

// File: tb/sim_mdio_c45_engine.sv
module sim_mdio_c45_engine;
    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [63:0] host_wdata = '0;
    logic [63:0] host_rdata;
    logic        busy, mdc, mdio_o, mdio_oe;
    logic        phy_drv = 1'b1;
    logic        mdio_line;

    always #5 clk = ~clk;

    assign mdio_line = mdio_oe ? mdio_o : phy_drv;

    mdio_c45_engine #(.HALF_DIV(HALF)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .busy       (busy),
        .mdc        (mdc),
        .mdio_i     (mdio_line),
        .mdio_o     (mdio_o),
        .mdio_oe    (mdio_oe)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // expected behaviour from the requirements
    function automatic bit exp_read(input logic [31:0] f);
        if (f[31:30] == 2'b01) return f[29:28] == 2'b10;
        return f[29];
    endfunction

    function automatic logic [1:0] exp_slot(input logic [31:0] f, input int k);
        bit rd = exp_read(f);
        if (k < 32) return 2'b11;
        if (k < 46) return {1'b1, f[63-k]};
        if (k == 46) return rd ? 2'b00 : 2'b11;
        if (k == 47) return rd ? 2'b00 : 2'b10;
        return rd ? 2'b00 : {1'b1, f[63-k]};
    endfunction

    function automatic logic [31:0] exp_back(input logic [31:0] f, input logic [15:0] phy);
        return exp_read(f) ? {f[31:16], phy} : f;
    endfunction

    // line logger: one slot per rising MDC edge, from the first driven preamble bit
    logic [63:0] log_oe, log_val;
    int          slot = 0;
    bit          logging = 1'b0, started = 1'b0, cur_read = 1'b0;
    logic [15:0] phy_data = '0;

    always @(posedge mdc) begin
        if (logging && slot < 64) begin
            if (!started && mdio_oe) started = 1'b1;
            if (started) begin
                log_oe[slot]  = mdio_oe;
                log_val[slot] = mdio_o;
                slot = slot + 1;
            end
        end
    end

    // PHY model: drives after each falling MDC edge
    always @(negedge mdc) begin
        #1;
        if (logging && cur_read && slot == 47) phy_drv = 1'b0;
        else if (logging && cur_read && slot >= 48 && slot < 64) phy_drv = phy_data[63-slot];
        else phy_drv = 1'b1;
    end

    // continuous MDC period (R3) and falling-edge-only change (R10) tracking
    logic pm, po, poe;
    int   run = 0, runs_seen = 0, r3_bad = 0, r10_bad = 0;
    bit   smp_valid = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (smp_valid) begin
                if ((mdio_o !== po || mdio_oe !== poe) && !(pm === 1'b1 && mdc === 1'b0))
                    r10_bad++;
                if (mdc !== pm) begin
                    if (runs_seen > 0 && run != HALF) r3_bad++;
                    runs_seen++;
                    run = 1;
                end else begin
                    run++;
                end
            end else begin
                run = 1;
            end
            smp_valid = 1'b1;
            pm  = mdc;
            po  = mdio_o;
            poe = mdio_oe;
        end
    end

    task automatic run_txn(input logic [31:0] f, input logic [31:0] upper,
                           input logic [15:0] phy, input bit inject);
        logic [63:0] eo, ev;
        cur_read = exp_read(f);
        phy_data = phy;
        slot     = 0;
        started  = 1'b0;
        logging  = 1'b1;
        @(negedge clk);
        host_wdata = {upper, f};
        host_wr    = 1'b1;
        @(negedge clk);
        host_wr    = 1'b0;
        chk("R1 busy after load", {63'd0, busy}, 64'd1);
        if (inject) begin
            repeat (40) @(negedge clk);
            host_wdata = {upper, ~f};
            host_wr    = 1'b1;
            @(negedge clk);
            host_wr    = 1'b0;
        end
        wait (slot == 64);
        #1;
        chk("R11 busy held through last bit", {63'd0, busy}, 64'd1);
        @(negedge mdc);
        #2;
        chk("R11 busy cleared at end", {63'd0, busy}, 64'd0);
        chk("R11 line released at end", {63'd0, mdio_oe}, 64'd0);
        logging = 1'b0;
        for (int k = 0; k < 64; k++) begin
            logic [1:0] s = exp_slot(f, k);
            eo[k] = s[1];
            ev[k] = s[1] & s[0];
        end
        chk("R4 preamble", {log_oe[31:0], log_val[31:0] & log_oe[31:0]}, {eo[31:0], ev[31:0]});
        chk("R5 header", {50'd0, log_oe[45:32], log_val[45:32] & log_oe[45:32]}, {50'd0, eo[45:32], ev[45:32]});
        chk("R7 turnaround class", {62'd0, log_oe[47:46]}, {62'd0, eo[47:46]});
        if (cur_read)
            chk("R8 read tail released", {28'd0, log_oe[63:46], log_val[63:46] & log_oe[63:46]}, {28'd0, eo[63:46], ev[63:46]});
        else
            chk("R6 write tail", {28'd0, log_oe[63:46], log_val[63:46] & log_oe[63:46]}, {28'd0, eo[63:46], ev[63:46]});
        @(negedge clk);
        if (inject)
            chk("R2 busy write ignored", host_rdata, {32'd0, exp_back(f, phy)});
        else if (cur_read)
            chk("R9 read data captured", host_rdata, {32'd0, exp_back(f, phy)});
        else
            chk("R1 readback upper zero", host_rdata, {32'd0, exp_back(f, phy)});
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R11 watchdog actual=hung expected=complete");
        finish_run();
    end

    initial begin
        int unsigned seed_val;
        seed_val = $urandom(32'd7);
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12 busy in reset", {63'd0, busy}, 64'd0);
        chk("R12 oe in reset", {63'd0, mdio_oe}, 64'd0);
        chk("R12 mdc in reset", {63'd0, mdc}, 64'd0);
        chk("R12 readback in reset", host_rdata, 64'd0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // directed: address, write, read, post-read
        run_txn({2'b00, 2'b00, 5'd0, 5'h1E, 2'b10, 16'h8000}, 32'd0, 16'h0000, 1'b0);
        run_txn({2'b00, 2'b01, 5'd1, 5'h1E, 2'b10, 16'h9F01}, 32'd0, 16'h0000, 1'b0);
        run_txn({2'b00, 2'b11, 5'd0, 5'h1E, 2'b10, 16'h0000}, 32'd0, 16'hA5C3, 1'b0);
        run_txn({2'b00, 2'b10, 5'd3, 5'h01, 2'b10, 16'hFFFF}, 32'd0, 16'h0001, 1'b0);
        // R7: Clause 22 start code, read and non-read opcodes
        run_txn({2'b01, 2'b10, 5'd2, 5'h04, 2'b10, 16'h0000}, 32'd0, 16'h8000, 1'b0);
        run_txn({2'b01, 2'b11, 5'd2, 5'h04, 2'b10, 16'h1234}, 32'd0, 16'hFFFF, 1'b0);
        // R1: upper half of write word ignored
        run_txn({2'b00, 2'b01, 5'd31, 5'h1F, 2'b10, 16'h5A5A}, 32'hDEADBEEF, 16'h0000, 1'b0);
        // R2: strobes while busy, on a read and on a write
        run_txn({2'b00, 2'b11, 5'd7, 5'h03, 2'b10, 16'h0F0F}, 32'h1, 16'h3C3C, 1'b1);
        run_txn({2'b00, 2'b00, 5'd9, 5'h05, 2'b10, 16'h7777}, 32'h0, 16'h0000, 1'b1);

        // constrained random frames
        for (int i = 0; i < 22; i++) begin
            logic [31:0] f;
            logic [1:0]  st;
            st = ($urandom % 4 == 0) ? 2'b01 : 2'($urandom % 4);
            f  = {st, 2'($urandom), 5'($urandom), 5'($urandom), 2'b10, 16'($urandom)};
            run_txn(f, $urandom, 16'($urandom), ($urandom % 5) == 0);
        end

        chk("R3 mdc half period violations", 64'(r3_bad), 64'd0);
        chk("R10 off-edge line changes", 64'(r10_bad), 64'd0);
        finish_run();
    end
endmodule